// File: doc/BRIEF.md
# SPI Slave Serial Shift Engine

This block is the bit-level engine of a slave-mode synchronous serial port. An external master drives the serial clock, an active-low frame select and the data-in line. The engine brings these into the system clock domain and finds the clock edges there. It then assembles receive words and shifts transmit words out, most significant bit first.

Whole words move between the engine and the port's FIFOs. On the transmit side a ready/valid handshake takes the next word at the moment it has to go out. On the receive side a one-cycle strobe delivers each completed word. Word length, clock polarity, clock phase, an internal loopback path and an enable are set by static configuration inputs. An underrun pulse marks each word that had to go out with no transmit data available.

The system clock must run at least four times faster than the serial clock. The master must keep the frame select low for at least one serial half period before its first clock edge.

Top module: `spi_slave_shifter`

## Requirements
- R1: The word length L follows from `size_field` (F) and `size_ext`. With `size_ext`=0, L = F+1. With `size_ext`=1, L = F+17. Results below 4 are treated as 4.
- R2: Each L-th sampled bit of a frame completes a receive word. `rx_valid` is then high for one cycle, 3 system clocks after the sampling edge reaches the `sclk` pin. `rx_data` holds the word right-aligned, first bit received in bit L-1, all higher bits zero.
- R3: The transmit word is shifted out on `miso` most significant bit first, starting at bit L-1 of `tx_data`. `miso` is 0 while the frame select is high or `enable` is low.
- R4: The idle level of `sclk` equals `cpol`, and the first edge after idle is the leading edge. With `cpha`=0, data is sampled on leading edges and changed on trailing edges. With `cpha`=1, data is sampled on trailing edges and changed on leading edges.
- R5: A transmit word is taken in the cycle where `tx_ready` and `tx_valid` are both high. `tx_ready` is a one-cycle request raised at the change edge that begins each word. With `cpha`=0 it is also raised when the frame opens, and the change edge after the last word of a frame also fetches.
- R6: When a fetch finds `tx_valid` low, `underrun` pulses for one cycle and that word is sent as all zeros.
- R7: With `loopback`=1, the receive side takes the bit being driven on `miso`, and `mosi` has no effect on `rx_data`.
- R8: Raising the frame select in the middle of a word discards the partial word without a receive strobe. The next frame starts at bit count zero.
- R9: After reset, and while `enable` is low, `rx_valid`, `tx_ready`, `underrun` and `miso` stay 0. Serial activity neither produces words nor consumes transmit data.
- R10: Words follow each other with no gap inside one frame. Each word is delivered and fetched on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Engine enable; low holds the engine idle and cleared |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | Clock phase: 0 samples on leading edges, 1 on trailing edges |
| loopback | input | 1 | Routes the outgoing bit to the receive side |
| size_field | input | SZ_W | Word length code |
| size_ext | input | 1 | Extended length select (adds 16 to the length) |
| sclk | input | 1 | Serial clock from the master |
| ss_n | input | 1 | Active-low frame select from the master |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| tx_data | input | MAX_W | Next transmit word, right-aligned |
| tx_valid | input | 1 | Transmit word available |
| tx_ready | output | 1 | Engine takes a transmit word this cycle |
| rx_data | output | MAX_W | Last completed receive word, right-aligned |
| rx_valid | output | 1 | One-cycle strobe for a completed receive word |
| underrun | output | 1 | One-cycle pulse when a fetch found no transmit word |

## Verification
Every serial input passes two synchronising flops. The engine acts on the following system edge, so `rx_valid`, `underrun` and a new `miso` bit are all due 3 system clocks after the pin change that causes them. A fetch at frame open is also due 3 clocks after `ss_n` falls. The bench master holds each serial half period for 6 system clocks. It reads `miso` at the end of a half period, just before it makes its own sampling edge, which leaves a margin of three clocks past the due cycle. Receive strobes and underrun pulses are watched on every falling system edge, against word and pulse counts that the bench computes from the requirements. The number of words left in the transmit queue is checked after each frame.

// File: rtl/sss_pkg.sv
// Shared definitions for the SPI slave shift engine.
// Assumes configuration inputs are static while a frame is open.
package sss_pkg;

    // Effective word length from the size code, clamped to [4, max_w].
    function automatic int unsigned word_len(input int unsigned field, input logic ext,
                                             input int unsigned sz_w, input int unsigned max_w);
        int unsigned l;
        l = ext ? field + (32'd1 << sz_w) + 32'd1 : field + 32'd1;
        if (l < 32'd4)
            l = 32'd4;
        if (l > max_w)
            l = max_w;
        return l;
    endfunction

endpackage

// File: rtl/sss_sync.sv
// Multi-flop synchroniser for a bundle of asynchronous serial pins.
// Assumes each bit is treated independently; STAGES must be at least 2.
module sss_sync #(
    parameter int unsigned W = 3,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    // Shift the pin values through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n)
            chain <= {STAGES{RST_VAL}};
        else
            chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sss_edge.sv
// Finds serial clock edges in the system domain and classifies them as
// sampling or change edges from the polarity and phase settings.
// Assumes the input is already synchronised.
module sss_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_s,
    input  logic cpol,
    input  logic cpha,
    output logic sample_ev,
    output logic shift_ev
);
    logic prev;
    logic rise, fall, lead, trail;

    // Remember last synchronised clock level.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev <= 1'b0;
        else
            prev <= sclk_s;
    end

    // Map raw edges onto leading/trailing, then onto sample/change.
    always_comb begin
        rise      = sclk_s & ~prev;
        fall      = ~sclk_s & prev;
        lead      = cpol ? fall : rise;
        trail     = cpol ? rise : fall;
        sample_ev = cpha ? trail : lead;
        shift_ev  = cpha ? lead : trail;
    end
endmodule

// File: rtl/sss_core.sv
// Bit counter, receive assembly and transmit shifting for one frame.
// Transmit words are left-aligned on load so the outgoing bit is always
// the top bit. Assumes sample and change events never share a cycle.
module sss_core #(
    parameter int unsigned MAX_W = 32,
    localparam int unsigned CW = $clog2(MAX_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             sample_ev,
    input  logic             shift_ev,
    input  logic             cpha,
    input  logic             loopback,
    input  logic [CW-1:0]    len,
    input  logic             mosi_s,
    input  logic [MAX_W-1:0] tx_data,
    input  logic             tx_valid,
    output logic             tx_ready,
    output logic             miso,
    output logic [MAX_W-1:0] rx_data,
    output logic             rx_valid,
    output logic             underrun
);
    localparam logic [CW-1:0] WMAX_C = CW'(MAX_W);
    localparam logic [CW-1:0] ONE_C  = CW'(1);

    logic             active_q;
    logic             start;
    logic             load_req;
    logic             last_bit;
    logic             din;
    logic [CW-1:0]    cnt;
    logic [MAX_W-1:0] sh_tx;
    logic [MAX_W-1:0] sh_rx;
    logic [MAX_W-1:0] tx_aligned;

    // Decode frame opening, fetch points and the incoming bit.
    always_comb begin
        start      = active & ~active_q;
        load_req   = active & ((start & ~cpha) | (shift_ev & (cnt == '0)));
        last_bit   = (cnt == len - ONE_C);
        din        = loopback ? sh_tx[MAX_W-1] : mosi_s;
        tx_aligned = tx_data << (WMAX_C - len);
    end

    assign tx_ready = load_req;
    assign miso     = active & sh_tx[MAX_W-1];

    // Frame state, transmit shifter and receive assembly.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt      <= '0;
            sh_tx    <= '0;
            sh_rx    <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
            underrun <= 1'b0;
        end else begin
            active_q <= active;
            rx_valid <= 1'b0;
            underrun <= 1'b0;
            if (!active) begin
                cnt   <= '0;
                sh_tx <= '0;
                sh_rx <= '0;
            end else begin
                if (load_req) begin
                    sh_tx    <= tx_valid ? tx_aligned : '0;
                    underrun <= ~tx_valid;
                end else if (shift_ev) begin
                    sh_tx <= sh_tx << 1;
                end else if (start) begin
                    sh_tx <= '0;
                end
                if (sample_ev) begin
                    if (last_bit) begin
                        rx_data  <= {sh_rx[MAX_W-2:0], din};
                        rx_valid <= 1'b1;
                        sh_rx    <= '0;
                        cnt      <= '0;
                    end else begin
                        sh_rx <= {sh_rx[MAX_W-2:0], din};
                        cnt   <= cnt + ONE_C;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/spi_slave_shifter.sv
// Top of the SPI slave shift engine: synchronises the serial pins, derives
// the word length and ties edge detection to the shift core.
// Assumes clk is at least 4x the serial clock and configuration is static
// during a frame.
module spi_slave_shifter #(
    parameter int unsigned MAX_W = 32,
    parameter int unsigned SZ_W = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             cpol,
    input  logic             cpha,
    input  logic             loopback,
    input  logic [SZ_W-1:0]  size_field,
    input  logic             size_ext,
    input  logic             sclk,
    input  logic             ss_n,
    input  logic             mosi,
    output logic             miso,
    input  logic [MAX_W-1:0] tx_data,
    input  logic             tx_valid,
    output logic             tx_ready,
    output logic [MAX_W-1:0] rx_data,
    output logic             rx_valid,
    output logic             underrun
);
    localparam int unsigned CW = $clog2(MAX_W + 1);

    logic [2:0]    pins_s;
    logic          sclk_s, ss_n_s, mosi_s;
    logic          sample_ev, shift_ev;
    logic          active;
    logic [CW-1:0] len;

    sss_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({sclk, ss_n, mosi}), .q(pins_s)
    );

    // Split synchronised pins, form frame activity and word length.
    always_comb begin
        sclk_s = pins_s[2];
        ss_n_s = pins_s[1];
        mosi_s = pins_s[0];
        active = enable & ~ss_n_s;
        len    = CW'(sss_pkg::word_len(32'(size_field), size_ext, SZ_W, MAX_W));
    end

    sss_edge u_edge (
        .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .cpol(cpol), .cpha(cpha),
        .sample_ev(sample_ev), .shift_ev(shift_ev)
    );

    sss_core #(.MAX_W(MAX_W)) u_core (
        .clk(clk), .rst_n(rst_n), .active(active), .sample_ev(sample_ev),
        .shift_ev(shift_ev), .cpha(cpha), .loopback(loopback), .len(len),
        .mosi_s(mosi_s), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .miso(miso), .rx_data(rx_data),
        .rx_valid(rx_valid), .underrun(underrun)
    );
endmodule

// File: rtl/sss_checker.sv
// Port-level properties of the SPI slave shift engine, bound to the top.
module sss_checker #(
    parameter int unsigned MAX_W = 32,
    parameter int unsigned SZ_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic [SZ_W-1:0]  size_field,
    input logic             size_ext,
    input logic             miso,
    input logic             tx_valid,
    input logic             tx_ready,
    input logic [MAX_W-1:0] rx_data,
    input logic             rx_valid,
    input logic             underrun
);
    int unsigned exp_len;

    always_comb exp_len = sss_pkg::word_len(32'(size_field), size_ext, SZ_W, MAX_W);

    // R2
    rx_strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R2
    rx_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> ((rx_data >> exp_len) == '0));

    // R5
    tx_request_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |=> !tx_ready);

    // R6
    underrun_only_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> !$past(tx_valid));

    // R9
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (!tx_ready && !miso));

    // R9
    disabled_no_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && $past(!enable)) |-> (!rx_valid && !underrun));
endmodule

bind spi_slave_shifter sss_checker #(.MAX_W(MAX_W), .SZ_W(SZ_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .size_field(size_field),
    .size_ext(size_ext), .miso(miso), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .underrun(underrun)
);

// File: tb/spi_slave_shifter_tb.sv
// Self-checking bench: behavioural SPI master, transmit queue and a
// per-clock monitor of receive strobes and underrun pulses.
module spi_slave_shifter_tb;
    localparam int HALF = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0, cpol = 1'b0, cpha = 1'b0, loopback = 1'b0;
    logic [3:0]  size_field = 4'd7;
    logic        size_ext = 1'b0;
    logic        sclk = 1'b0, ss_n = 1'b1, mosi = 1'b0;
    logic        miso, tx_ready, rx_valid, underrun;
    logic [31:0] tx_data = '0, rx_data;
    logic        tx_valid = 1'b0;
    logic        pop_pending = 1'b0;

    logic [31:0] txq[$];
    logic [31:0] exp_rx[$];
    int          checks = 0, errors = 0, und_cnt = 0;
    bit          finished = 0;

    always #2.5 clk = ~clk;

    spi_slave_shifter u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cpol(cpol), .cpha(cpha),
        .loopback(loopback), .size_field(size_field), .size_ext(size_ext),
        .sclk(sclk), .ss_n(ss_n), .mosi(mosi), .miso(miso), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data),
        .rx_valid(rx_valid), .underrun(underrun)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // Transmit FIFO model: handshake seen at posedge, popped at negedge.
    always @(posedge clk) pop_pending <= tx_ready && tx_valid;
    always @(negedge clk) begin
        if (pop_pending && txq.size() > 0) void'(txq.pop_front());
        tx_valid = (txq.size() > 0);
        tx_data  = (txq.size() > 0) ? txq[0] : 32'h0;
    end

    // Monitor of receive strobes and underrun pulses on every clock.
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            if (exp_rx.size() == 0)
                check(0, "R2/R8/R9 unexpected rx word", rx_data, 32'h0);
            else
                check(rx_data == exp_rx[0], "R2 rx word", rx_data, exp_rx[0]);
            if (exp_rx.size() > 0) void'(exp_rx.pop_front());
        end
        if (rst_n && underrun) und_cnt++;
    end

    function automatic int exp_len(input int f, input bit e);
        int l;
        l = e ? f + 17 : f + 1;
        if (l < 4) l = 4;
        return l;
    endfunction

    function automatic logic [31:0] lmask(input int l);
        return 32'hFFFF_FFFF >> (32 - l);
    endfunction

    task automatic cw(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Clocks one word as master; stops before bit index stop_at when >= 0.
    task automatic master_word(input logic [31:0] w, input int l, input int stop_at,
                               output logic [31:0] got);
        got = '0;
        for (int i = 0; i < l; i++) begin
            if (stop_at >= 0 && i == stop_at) return;
            if (!cpha) begin
                mosi = w[l-1-i];
                cw(HALF);
                got = {got[30:0], miso};
                sclk = ~cpol;
                cw(HALF);
                sclk = cpol;
            end else begin
                sclk = ~cpol;
                mosi = w[l-1-i];
                cw(HALF);
                got = {got[30:0], miso};
                sclk = cpol;
                cw(HALF);
            end
        end
    endtask

    task automatic open_frame();
        sclk = cpol;
        cw(2 * HALF);
        ss_n = 1'b0;
        cw(2 * HALF);
    endtask

    task automatic close_frame();
        cw(HALF);
        ss_n = 1'b1;
        cw(2 * HALF);
    endtask

    // One frame of nwords words with navail transmit words queued beforehand.
    task automatic run_case(input string tag, input bit p, input bit h, input int f, input bit e,
                            input bit lb, input int nwords, input int navail, input int seed);
        int l, fetches, und0, exp_und, left;
        logic [31:0] sw[8];
        logic [31:0] mw, em, got;
        cpol = p; cpha = h; size_field = 4'(f); size_ext = e; loopback = lb;
        l = exp_len(f, e);
        fetches = nwords + (h ? 0 : 1);
        for (int k = 0; k < 8; k++) sw[k] = 32'hC2B2_AE35 ^ (32'h9E37_79B9 * (k + seed));
        for (int k = 0; k < navail; k++) txq.push_back(sw[k]);
        cw(2);
        und0 = und_cnt;
        open_frame();
        for (int wi = 0; wi < nwords; wi++) begin
            mw = 32'h85EB_CA6B * (wi + seed + 3) ^ 32'h1357_9BDF;
            em = (wi < navail) ? (sw[wi] & lmask(l)) : 32'h0;
            exp_rx.push_back(lb ? em : (mw & lmask(l)));
            master_word(mw, l, -1, got);
            check(got == em, {tag, " R3 miso word"}, got, em);
        end
        close_frame();
        exp_und = (fetches > navail) ? fetches - navail : 0;
        left = (navail > fetches) ? navail - fetches : 0;
        check(und_cnt - und0 == exp_und, {tag, " R6 underrun count"}, 32'(und_cnt - und0), 32'(exp_und));
        check(txq.size() == left, {tag, " R5 tx words left"}, 32'(txq.size()), 32'(left));
        check(exp_rx.size() == 0, {tag, " R2 rx words missing"}, 32'(exp_rx.size()), 32'h0);
        txq.delete();
        exp_rx.delete();
        cw(2);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual %h expected %h", 32'h1, 32'h0);
        finish_run();
    end

    initial begin : main
        logic [31:0] got, mw;
        int u0;
        cw(4);
        rst_n = 1'b1;
        cw(1);
        // R9 reset state
        check(rx_valid == 0, "R9 reset rx_valid", 32'(rx_valid), 32'h0);
        check(tx_ready == 0, "R9 reset tx_ready", 32'(tx_ready), 32'h0);
        check(miso == 0, "R9 reset miso", 32'(miso), 32'h0);
        check(underrun == 0, "R9 reset underrun", 32'(underrun), 32'h0);
        enable = 1'b1;
        cw(4);

        run_case("R4 mode0 L8", 0, 0, 7, 0, 0, 2, 3, 1);
        run_case("R4 mode1 L8", 0, 1, 7, 0, 0, 2, 2, 2);
        run_case("R4 mode2 L16", 1, 0, 15, 0, 0, 1, 2, 3);
        run_case("R4 mode3 L12", 1, 1, 11, 0, 0, 2, 2, 4);
        run_case("R1 L17", 0, 0, 0, 1, 0, 1, 2, 5);
        run_case("R1 L32", 1, 1, 15, 1, 0, 2, 2, 6);
        run_case("R1 clamp L4", 0, 1, 1, 0, 0, 3, 3, 7);
        run_case("R10 back-to-back L4", 0, 0, 3, 0, 0, 4, 5, 8);
        run_case("R6 mode1 short", 0, 1, 7, 0, 0, 3, 1, 9);
        run_case("R6 mode0 empty", 0, 0, 7, 0, 0, 1, 0, 10);
        run_case("R7 loopback", 0, 0, 7, 0, 1, 2, 3, 11);

        // R8: partial word discarded, next frame starts clean (mode 3, L8)
        cpol = 1; cpha = 1; size_field = 4'd7; size_ext = 0; loopback = 0;
        txq.push_back(32'h0000_00A7);
        txq.push_back(32'h0000_005C);
        cw(2);
        u0 = und_cnt;
        open_frame();
        master_word(32'h0000_00F0, 8, 3, got);
        close_frame();
        check(exp_rx.size() == 0, "R8 no rx after abort", 32'(exp_rx.size()), 32'h0);
        open_frame();
        mw = 32'h0000_0093;
        exp_rx.push_back(mw);
        master_word(mw, 8, -1, got);
        check(got == 32'h5C, "R8 miso after abort", got, 32'h5C);
        close_frame();
        check(exp_rx.size() == 0, "R8 rx word after abort", 32'(exp_rx.size()), 32'h0);
        check(txq.size() == 0, "R8 tx words left", 32'(txq.size()), 32'h0);
        check(und_cnt == u0, "R8 underrun count", 32'(und_cnt - u0), 32'h0);
        txq.delete(); exp_rx.delete();

        // R9: disabled engine ignores the master and keeps its queue
        enable = 1'b0;
        cpol = 0; cpha = 0;
        txq.push_back(32'h0000_00FF);
        cw(2);
        u0 = und_cnt;
        open_frame();
        master_word(32'h0000_0066, 8, -1, got);
        close_frame();
        check(got == 32'h0, "R9 miso while disabled", got, 32'h0);
        check(txq.size() == 1, "R9 tx word kept", 32'(txq.size()), 32'h1);
        check(und_cnt == u0, "R9 no underrun", 32'(und_cnt - u0), 32'h0);
        txq.delete();
        enable = 1'b1;
        cw(4);

        finish_run();
    end
endmodule